// File: doc/BRIEF.md
# Segment-Page Map Address Translator

This block turns a 32-bit virtual address into a physical address using two maps held in on-chip storage: a segment map and a page map. The segment map is indexed by the current context number together with segment bits of the virtual address, and returns a page-group number. The page map is indexed by that group number together with the page bits of the address, and returns a 32-bit page entry. The entry grants or refuses the access. When the access is granted, the entry supplies the frame number, the non-cacheable flag and the space type, and the block then stores it back with its used bit set (and its modified bit set on a write). An address whose top three bits are neither all zeros nor all ones lies in the address hole and is refused before either map is read.

A CPU-side request port with a valid/ready handshake accepts one translation at a time. A configuration port lets software write and read the context register, segment-map entries and page-map entries. The control is a four-state machine. `ST_IDLE` accepts work. An accepted request with a hole address answers at once and stays in `ST_IDLE`. Any other accepted request moves to `ST_SEGRD`. `ST_SEGRD` always moves to `ST_PTERD`, which presents the result. A granted access then moves to `ST_WBACK`, where the updated entry is written back. A refused access returns to `ST_IDLE`, and `ST_WBACK` also always returns to `ST_IDLE`. A configuration access is served only in `ST_IDLE`, where it leaves the state unchanged.

Top module: `segpage_xlate`

## Requirements
- R1: A request whose address bits 31:29 are not 000 and not 111 answers with fault code 1 (hole) in the cycle after acceptance, reads no map entry and writes nothing back.
- R2: The segment-map index is {context register, address bits 18+VSEG_W-1:18} (VSEG_W is 7 by default and 12 in a full build). The page-map index is {page-group number, address bits 17:12}. Changing the context register changes which segment entry is used.
- R3: A page entry with bit 31 (valid) clear gives fault code 2 (invalid).
- R4: Fault code 3 (protection) is given when a write meets an entry with bit 30 (write allowed) clear, or when a user-mode access meets an entry with bit 29 (supervisor only) set.
- R5: A granted access gives fault code 0, a physical address of {entry bits 18:0, address bits 11:0}, non-cacheable = entry bit 28, and space type = entry bits 27:26, passed unchanged (0 on-board memory, 1 on-board I/O, 2 16-bit VME, 3 32-bit VME).
- R6: After a granted access, the page entry reads back with bit 25 (used) set, with bit 24 (modified) also set if the access was a write, and with all other bits unchanged.
- R7: A refused access leaves the page entry unchanged, and its response carries a physical address, non-cacheable flag and space type of zero.
- R8: For a request outside the hole, resp_valid is high for one cycle, three cycles after acceptance. req_ready and cfg_ready stay low from acceptance until the machine is back in ST_IDLE.
- R9: In ST_IDLE a configuration access takes priority: req_ready is low while cfg_en is high. No configuration access is accepted while a translation is in flight.
- R10: An accepted configuration read raises cfg_rvalid in the next cycle, with cfg_rdata zero-extended from the selected item. cfg_sel 0 selects the context register, 1 the segment map and 2 the page map. cfg_sel 3 reads zero and writes nothing.
- R11: After reset, req_ready and cfg_ready are high, resp_valid and cfg_rvalid are low, and the context register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| resp_valid | output | 1 | Result present, one-cycle pulse |
| resp_fault | output | 2 | 0 none, 1 hole, 2 invalid, 3 protection |
| resp_pa | output | PFN_W+OFF_W | Physical address |
| resp_nc | output | 1 | Access must bypass the cache |
| resp_space | output | 2 | Space type from the page entry |
| cfg_en | input | 1 | Configuration access request |
| cfg_we | input | 1 | Configuration access is a write |
| cfg_sel | input | 2 | Target: 0 context, 1 segment map, 2 page map, 3 none |
| cfg_addr | input | CFG_AW | Entry index in the selected map |
| cfg_wdata | input | 32 | Write data |
| cfg_ready | output | 1 | Configuration access can be accepted |
| cfg_rvalid | output | 1 | Read data present |
| cfg_rdata | output | 32 | Read data |

## Verification
The translation path is driven with one table that sweeps granted reads and writes, user and supervisor mode against the supervisor-only bit, writes against read-only entries, an invalid entry, and two addresses on each side of the hole. Each row expects a specific fault code, so a wrong check order or a swapped protection condition shows up as the wrong code. Addresses with all-ones top bits and with different offsets separate the frame/offset concatenation from the index path. The entries are read back afterwards, which shows whether the used and modified bits were set only by the accesses that were granted. A context switch that maps the same virtual address to another group confirms that the context takes part in the index, and a request raised together with a configuration read shows the priority.

// File: rtl/sp_xlate_pkg.sv
package sp_xlate_pkg;

    localparam int VA_W   = 32;
    localparam int PTE_W  = 32;

    // Page entry bit positions (decoded by the check logic)
    localparam int PTE_VALID = 31;
    localparam int PTE_WRITE = 30;
    localparam int PTE_SUPER = 29;
    localparam int PTE_NOCAC = 28;
    localparam int PTE_SPHI  = 27;
    localparam int PTE_SPLO  = 26;
    localparam int PTE_USED  = 25;
    localparam int PTE_MOD   = 24;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_HOLE    = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEGRD = 2'd1,
        ST_PTERD = 2'd2,
        ST_WBACK = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        SEL_CTX  = 2'd0,
        SEL_SEG  = 2'd1,
        SEL_PAGE = 2'd2,
        SEL_NONE = 2'd3
    } cfg_sel_e;

endpackage

// File: rtl/sp_map_ram.sv
module sp_map_ram #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        rdata <= store[raddr];
    end

endmodule

// File: rtl/sp_va_hole.sv
module sp_va_hole #(
    parameter int TOP_W = 3
) (
    input  logic [TOP_W-1:0] va_top,
    output logic             in_hole
);
    // Legal only when the top bits are a sign extension (all 0 or all 1)
    always_comb begin
        in_hole = !((&va_top) || !(|va_top));
    end

endmodule

// File: rtl/sp_pte_check.sv
module sp_pte_check
    import sp_xlate_pkg::*;
#(
    parameter int PFN_W = 19,
    parameter int OFF_W = 12
) (
    input  logic [PTE_W-1:0]       pte,
    input  logic                   is_write,
    input  logic                   is_user,
    input  logic [OFF_W-1:0]       offset,
    output fault_e                 fault,
    output logic [PTE_W-1:0]       pte_upd,
    output logic [PFN_W+OFF_W-1:0] pa,
    output logic                   nc,
    output logic [1:0]             space
);
    logic deny_write;
    logic deny_user;

    always_comb begin
        deny_write = is_write && !pte[PTE_WRITE];
        deny_user  = is_user  &&  pte[PTE_SUPER];

        if (!pte[PTE_VALID]) begin
            fault = FLT_INVALID;
        end else if (deny_write || deny_user) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end

        pte_upd           = pte;
        pte_upd[PTE_USED] = 1'b1;
        pte_upd[PTE_MOD]  = pte[PTE_MOD] | is_write;

        if (fault == FLT_NONE) begin
            pa    = {pte[PFN_W-1:0], offset};
            nc    = pte[PTE_NOCAC];
            space = pte[PTE_SPHI:PTE_SPLO];
        end else begin
            pa    = '0;
            nc    = 1'b0;
            space = 2'd0;
        end
    end

endmodule

// File: rtl/segpage_xlate.sv
module segpage_xlate
    import sp_xlate_pkg::*;
#(
    parameter int CTX_W  = 3,
    parameter int VSEG_W = 7,
    parameter int VPG_W  = 6,
    parameter int OFF_W  = 12,
    parameter int PMEG_W = 4,
    parameter int PFN_W  = 19,
    parameter int CFG_AW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [31:0]            req_va,
    input  logic                   req_write,
    input  logic                   req_user,
    output logic                   resp_valid,
    output logic [1:0]             resp_fault,
    output logic [PFN_W+OFF_W-1:0] resp_pa,
    output logic                   resp_nc,
    output logic [1:0]             resp_space,
    input  logic                   cfg_en,
    input  logic                   cfg_we,
    input  logic [1:0]             cfg_sel,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [31:0]            cfg_wdata,
    output logic                   cfg_ready,
    output logic                   cfg_rvalid,
    output logic [31:0]            cfg_rdata
);
    localparam int SMAP_AW = CTX_W + VSEG_W;
    localparam int PMAP_AW = PMEG_W + VPG_W;
    localparam int VPG_LO  = OFF_W;
    localparam int VSEG_LO = OFF_W + VPG_W;
    localparam int PA_W    = PFN_W + OFF_W;
    localparam int HOLE_W  = 3;

    state_e state_q, state_d;

    logic                 req_acc, cfg_acc, va_hole;
    logic [CTX_W-1:0]     ctx_q;
    logic [OFF_W-1:0]     off_q;
    logic [VPG_W-1:0]     vpg_q;
    logic                 wr_q, user_q;
    logic [PMAP_AW-1:0]   pg_idx_q;
    logic [PTE_W-1:0]     wb_data_q;
    logic [1:0]           cfg_sel_q;
    logic                 cfg_rvalid_q;

    logic                 resp_valid_q, resp_nc_q;
    fault_e               resp_fault_q;
    logic [PA_W-1:0]      resp_pa_q;
    logic [1:0]           resp_space_q;

    logic                 sm_we;
    logic [SMAP_AW-1:0]   sm_raddr;
    logic [PMEG_W-1:0]    sm_rdata;
    logic                 pm_we;
    logic [PMAP_AW-1:0]   pm_raddr, pm_waddr;
    logic [PTE_W-1:0]     pm_wdata, pm_rdata;

    fault_e               chk_fault;
    logic [PTE_W-1:0]     chk_upd;
    logic [PA_W-1:0]      chk_pa;
    logic                 chk_nc;
    logic [1:0]           chk_space;

    logic                 unused_bits;
    assign unused_bits = ^{req_va, cfg_addr, cfg_wdata};

    // Handshake: only the idle state takes work; configuration wins
    assign cfg_ready = (state_q == ST_IDLE);
    assign req_ready = (state_q == ST_IDLE) && !cfg_en;
    assign req_acc   = req_valid && req_ready;
    assign cfg_acc   = cfg_en && cfg_ready;

    sp_va_hole #(.TOP_W(HOLE_W)) u_hole (
        .va_top  (req_va[31:32-HOLE_W]),
        .in_hole (va_hole)
    );

    // Segment map: read by config or by a new request
    assign sm_we    = cfg_acc && cfg_we && (cfg_sel == SEL_SEG);
    assign sm_raddr = cfg_acc ? cfg_addr[SMAP_AW-1:0]
                              : {ctx_q, req_va[VSEG_LO +: VSEG_W]};

    sp_map_ram #(.AW(SMAP_AW), .DW(PMEG_W)) u_segmap (
        .clk   (clk),
        .we    (sm_we),
        .waddr (cfg_addr[SMAP_AW-1:0]),
        .wdata (cfg_wdata[PMEG_W-1:0]),
        .raddr (sm_raddr),
        .rdata (sm_rdata)
    );

    // Page map: read in ST_SEGRD, written by config or write-back
    assign pm_raddr = (state_q == ST_SEGRD) ? {sm_rdata, vpg_q}
                                            : cfg_addr[PMAP_AW-1:0];
    assign pm_we    = (state_q == ST_WBACK) ||
                      (cfg_acc && cfg_we && (cfg_sel == SEL_PAGE));
    assign pm_waddr = (state_q == ST_WBACK) ? pg_idx_q : cfg_addr[PMAP_AW-1:0];
    assign pm_wdata = (state_q == ST_WBACK) ? wb_data_q : cfg_wdata;

    sp_map_ram #(.AW(PMAP_AW), .DW(PTE_W)) u_pagemap (
        .clk   (clk),
        .we    (pm_we),
        .waddr (pm_waddr),
        .wdata (pm_wdata),
        .raddr (pm_raddr),
        .rdata (pm_rdata)
    );

    sp_pte_check #(.PFN_W(PFN_W), .OFF_W(OFF_W)) u_check (
        .pte      (pm_rdata),
        .is_write (wr_q),
        .is_user  (user_q),
        .offset   (off_q),
        .fault    (chk_fault),
        .pte_upd  (chk_upd),
        .pa       (chk_pa),
        .nc       (chk_nc),
        .space    (chk_space)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_acc && !va_hole) begin
                    state_d = ST_SEGRD;
                end
            end
            ST_SEGRD: state_d = ST_PTERD;
            ST_PTERD: state_d = (chk_fault == FLT_NONE) ? ST_WBACK : ST_IDLE;
            ST_WBACK: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Data and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q        <= '0;
            off_q        <= '0;
            vpg_q        <= '0;
            wr_q         <= 1'b0;
            user_q       <= 1'b0;
            pg_idx_q     <= '0;
            wb_data_q    <= '0;
            cfg_sel_q    <= SEL_NONE;
            cfg_rvalid_q <= 1'b0;
            resp_valid_q <= 1'b0;
            resp_fault_q <= FLT_NONE;
            resp_pa_q    <= '0;
            resp_nc_q    <= 1'b0;
            resp_space_q <= 2'd0;
        end else begin
            resp_valid_q <= 1'b0;
            cfg_rvalid_q <= cfg_acc && !cfg_we;
            if (cfg_acc) begin
                cfg_sel_q <= cfg_sel;
            end
            if (cfg_acc && cfg_we && (cfg_sel == SEL_CTX)) begin
                ctx_q <= cfg_wdata[CTX_W-1:0];
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (req_acc) begin
                        off_q  <= req_va[OFF_W-1:0];
                        vpg_q  <= req_va[VPG_LO +: VPG_W];
                        wr_q   <= req_write;
                        user_q <= req_user;
                        if (va_hole) begin
                            resp_valid_q <= 1'b1;
                            resp_fault_q <= FLT_HOLE;
                            resp_pa_q    <= '0;
                            resp_nc_q    <= 1'b0;
                            resp_space_q <= 2'd0;
                        end
                    end
                end
                ST_SEGRD: begin
                    pg_idx_q <= pm_raddr;
                end
                ST_PTERD: begin
                    resp_valid_q <= 1'b1;
                    resp_fault_q <= chk_fault;
                    resp_pa_q    <= chk_pa;
                    resp_nc_q    <= chk_nc;
                    resp_space_q <= chk_space;
                    wb_data_q    <= chk_upd;
                end
                ST_WBACK: begin
                end
            endcase
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_fault = resp_fault_q;
    assign resp_pa    = resp_pa_q;
    assign resp_nc    = resp_nc_q;
    assign resp_space = resp_space_q;
    assign cfg_rvalid = cfg_rvalid_q;

    always_comb begin
        cfg_rdata = '0;
        if (cfg_rvalid_q) begin
            unique case (cfg_sel_q)
                SEL_CTX:  cfg_rdata = {{(32-CTX_W){1'b0}}, ctx_q};
                SEL_SEG:  cfg_rdata = {{(32-PMEG_W){1'b0}}, sm_rdata};
                SEL_PAGE: cfg_rdata = pm_rdata;
                default:  cfg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/segpage_xlate_chk.sv
module segpage_xlate_chk #(
    parameter int PA_W = 31
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic [2:0]      va_top,
    input logic            cfg_en,
    input logic            cfg_we,
    input logic            cfg_ready,
    input logic            cfg_rvalid,
    input logic            resp_valid,
    input logic [1:0]      resp_fault,
    input logic [PA_W-1:0] resp_pa,
    input logic            resp_nc,
    input logic [1:0]      resp_space
);
    logic top_legal;
    assign top_legal = (va_top == 3'b000) || (va_top == 3'b111);

    assert_hole_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !top_legal) |=> (resp_valid && resp_fault == 2'd1));

    assert_zero_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 2'd0) |-> (resp_pa == '0 && !resp_nc && resp_space == 2'd0));

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && top_legal) |=> (!req_ready && !cfg_ready));

    assert_result_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && top_legal) |-> ##3 resp_valid);

    assert_cfg_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_ready) |-> !req_ready);

    assert_cfg_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && cfg_ready && !cfg_we) |=> cfg_rvalid);

endmodule

bind segpage_xlate segpage_xlate_chk #(.PA_W(PFN_W + OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .va_top     (req_va[31:29]),
    .cfg_en     (cfg_en),
    .cfg_we     (cfg_we),
    .cfg_ready  (cfg_ready),
    .cfg_rvalid (cfg_rvalid),
    .resp_valid (resp_valid),
    .resp_fault (resp_fault),
    .resp_pa    (resp_pa),
    .resp_nc    (resp_nc),
    .resp_space (resp_space)
);

// File: tb/segpage_xlate_test.sv
module segpage_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
    logic [31:0] req_va = '0;
    logic        req_ready, resp_valid, resp_nc;
    logic [1:0]  resp_fault, resp_space;
    logic [30:0] resp_pa;
    logic        cfg_en = 1'b0, cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_ready, cfg_rvalid;
    logic [31:0] cfg_rdata;

    always #2 clk = ~clk;

    segpage_xlate uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_user(req_user),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_pa(resp_pa),
        .resp_nc(resp_nc), .resp_space(resp_space),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_rvalid(cfg_rvalid),
        .cfg_rdata(cfg_rdata)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 100000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input int addr, input logic [31:0] data);
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_sel = sel;
        cfg_addr = addr[15:0]; cfg_wdata = data;
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] sel, input int addr,
                            output logic [31:0] data, output logic ok);
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_sel = sel; cfg_addr = addr[15:0];
        @(negedge clk);
        ok = cfg_rvalid; data = cfg_rdata;
        cfg_en = 1'b0;
    endtask

    task automatic wait_resp(output int lat, output logic busy1);
        lat = 1;
        busy1 = !req_ready && !cfg_ready;
        while (!resp_valid && lat < 20) begin
            @(negedge clk);
            lat = lat + 1;
        end
    endtask

    task automatic xlate(input logic [31:0] va, input logic wr, input logic usr,
                         output logic [1:0] flt, output logic [30:0] pa,
                         output logic nc, output logic [1:0] sp,
                         output int lat, output logic busy1);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        wait_resp(lat, busy1);
        flt = resp_fault; pa = resp_pa; nc = resp_nc; sp = resp_space;
    endtask

    // {va, write, user, fault, pa, nc, space}
    localparam int NV = 10;
    localparam logic [69:0] VECS [NV] = '{
        {32'h00040123, 1'b0, 1'b1, 2'd0, 31'h12345123, 1'b1, 2'd1},
        {32'h00040123, 1'b1, 1'b1, 2'd0, 31'h12345123, 1'b1, 2'd1},
        {32'h00041FFF, 1'b0, 1'b0, 2'd0, 31'h7FFFFFFF, 1'b0, 2'd2},
        {32'h00041FFF, 1'b0, 1'b1, 2'd3, 31'h0,        1'b0, 2'd0},
        {32'h00041FFF, 1'b1, 1'b0, 2'd3, 31'h0,        1'b0, 2'd0},
        {32'h00042000, 1'b0, 1'b0, 2'd2, 31'h0,        1'b0, 2'd0},
        {32'h20000000, 1'b0, 1'b0, 2'd1, 31'h0,        1'b0, 2'd0},
        {32'hC0040123, 1'b1, 1'b0, 2'd1, 31'h0,        1'b0, 2'd0},
        {32'hE0085456, 1'b1, 1'b0, 2'd0, 31'h00ABC456, 1'b0, 2'd3},
        {32'h00085456, 1'b0, 1'b1, 2'd0, 31'h00ABC456, 1'b0, 2'd3}
    };

    initial begin
        logic [1:0]  flt, sp;
        logic [30:0] pa;
        logic        nc, ok, busy1;
        logic [31:0] rd;
        int          lat;

        repeat (3) @(negedge clk);
        chk("R11 req_ready in reset", {31'b0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 req_ready", {31'b0, req_ready}, 32'd1);
        chk("R11 cfg_ready", {31'b0, cfg_ready}, 32'd1);
        chk("R11 resp_valid", {31'b0, resp_valid}, 32'd0);
        chk("R11 cfg_rvalid", {31'b0, cfg_rvalid}, 32'd0);
        cfg_read(2'd0, 0, rd, ok);
        chk("R11 context after reset", rd, 32'd0);

        // Maps: context 5 -> seg 1 = group 3, seg 2 = group 9; context 0 seg 1 = group 4
        cfg_write(2'd0, 0, 32'd5);
        cfg_write(2'd1, 5*128 + 1, 32'd3);
        cfg_write(2'd1, 5*128 + 2, 32'd9);
        cfg_write(2'd1, 0*128 + 1, 32'd4);
        cfg_write(2'd2, 3*64 + 0, 32'hD4012345);
        cfg_write(2'd2, 3*64 + 1, 32'hA807FFFF);
        cfg_write(2'd2, 3*64 + 2, 32'h40000077);
        cfg_write(2'd2, 9*64 + 5, 32'hCC000ABC);
        cfg_write(2'd2, 4*64 + 0, 32'hC0000042);
        cfg_write(2'd3, 0, 32'hFFFFFFFF);

        cfg_read(2'd0, 0, rd, ok);
        chk("R10 context readback", rd, 32'd5);
        chk("R10 cfg_rvalid", {31'b0, ok}, 32'd1);
        cfg_read(2'd1, 5*128 + 2, rd, ok);
        chk("R10 segment entry readback", rd, 32'd9);
        cfg_read(2'd3, 0, rd, ok);
        chk("R10 unused select reads zero", rd, 32'd0);
        cfg_read(2'd0, 0, rd, ok);
        chk("R10 unused select writes nothing", rd, 32'd5);

        for (int i = 0; i < NV; i++) begin
            logic [69:0] v;
            v = VECS[i];
            xlate(v[69:38], v[37], v[36], flt, pa, nc, sp, lat, busy1);
            chk("R1 R3 R4 fault code", {30'b0, flt}, {30'b0, v[35:34]});
            chk("R5 R7 physical address", {1'b0, pa}, {1'b0, v[33:3]});
            chk("R5 R7 non-cacheable", {31'b0, nc}, {31'b0, v[2]});
            chk("R5 R7 space type", {30'b0, sp}, {30'b0, v[1:0]});
            chk("R1 R8 latency", lat, (v[35:34] == 2'd1) ? 32'd1 : 32'd3);
            chk("R8 busy while in flight", {31'b0, busy1},
                (v[35:34] == 2'd1) ? 32'd0 : 32'd1);
        end

        // Write-back results (R6, R7)
        cfg_read(2'd2, 3*64 + 0, rd, ok);
        chk("R6 used and modified set", rd, 32'hD7012345);
        cfg_read(2'd2, 3*64 + 1, rd, ok);
        chk("R6 used set by read only", rd, 32'hAA07FFFF);
        cfg_read(2'd2, 3*64 + 2, rd, ok);
        chk("R7 invalid entry untouched", rd, 32'h40000077);
        cfg_read(2'd2, 9*64 + 5, rd, ok);
        chk("R6 write entry marked", rd, 32'hCF000ABC);

        // Context switch selects another group (R2)
        cfg_write(2'd0, 0, 32'd0);
        xlate(32'h00040123, 1'b0, 1'b0, flt, pa, nc, sp, lat, busy1);
        chk("R2 context selects group", {1'b0, pa}, 32'h00042123);
        chk("R2 context fault", {30'b0, flt}, 32'd0);

        // Priority of configuration over a request (R9)
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_addr = '0;
        req_valid = 1'b1; req_va = 32'h00040123; req_write = 1'b1; req_user = 1'b0;
        #1;
        chk("R9 request held off", {31'b0, req_ready}, 32'd0);
        chk("R9 config accepted", {31'b0, cfg_ready}, 32'd1);
        @(negedge clk);
        chk("R9 config read served first", {31'b0, cfg_rvalid}, 32'd1);
        cfg_en = 1'b0;
        #1;
        chk("R9 request taken next", {31'b0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        wait_resp(lat, busy1);
        chk("R9 no config in flight", {31'b0, busy1}, 32'd1);
        chk("R8 latency after priority", lat, 32'd3);
        chk("R5 pa after priority", {1'b0, resp_pa}, 32'h00042123);
        cfg_read(2'd2, 4*64 + 0, rd, ok);
        chk("R6 write-back context 0", rd, 32'hC3000042);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule